// File: doc/BRIEF.md
# Multicycle Processor Main Control Sequencer

This block is the control state machine of a multicycle processor that runs a small RISC subset: word load, word store, register-to-register ALU operations, branch-if-equal and jump. The datapath it steers has one memory that holds both instructions and data, one ALU that also does the program-counter increment, and a Target register that holds a branch destination before the branch condition is known. The sequencer sees only the opcode field held in the instruction register and the equality flag produced by the ALU. In each cycle it drives the PC write enable and source select, the memory address select, the memory read and write strobes, the instruction register and Target write enables, both ALU operand selects, the ALU operation class, the register-file write enable and the write-back data select.

Every instruction starts with a fetch step, where the ALU forms PC+4 and the PC takes it, and a decode step, where the ALU adds the shifted sign-extended offset to the new PC and the Target register captures the sum. From then on the opcode picks the path: loads and stores compute an address and access memory, ALU operations execute and write back, branches compare and conditionally load the PC from Target, and jumps load the PC from the jump field. An opcode that matches none of the five classes returns straight to fetch. The opcode input must stay stable from the end of fetch until the instruction completes, as it does when it comes from the instruction register.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in its fetch step. In fetch the outputs are mem_rd=1, iord=0, ir_wr=1, alu_a_sel=0 (PC), alu_b_sel=01 (constant 4), alu_op=00 (add), pc_wr=1 and pc_src=00 (ALU result), with every other output 0.
- R2: The cycle after fetch is always the decode step, for every opcode: tgt_wr=1, alu_a_sel=0, alu_b_sel=11 (offset shifted left by two), alu_op=00, all other outputs 0.
- R3: For opcode 0x23 (load), decode is followed by an address step (alu_a_sel=1 register, alu_b_sel=10 sign-extended offset, alu_op=00), then a read step (mem_rd=1, iord=1), then a write-back step (reg_wr=1, mem2reg=1), then fetch: five cycles in all.
- R4: For opcode 0x2B (store), decode is followed by the same address step, then a write step (mem_wr=1, iord=1), then fetch: four cycles in all.
- R5: For opcode 0x00 (register ALU operation), decode is followed by an execute step (alu_a_sel=1, alu_b_sel=00 second register, alu_op=10 function-field controlled), then a write-back step (reg_wr=1, mem2reg=0), then fetch: four cycles in all.
- R6: For opcode 0x04 (branch-if-equal), decode is followed by a compare step (alu_a_sel=1, alu_b_sel=00, alu_op=01 subtract, pc_src=01 Target) in which pc_wr follows alu_eq within the same cycle, then fetch: three cycles in all.
- R7: For opcode 0x02 (jump), decode is followed by a jump step with pc_wr=1, pc_src=10 (jump field) and tgt_wr=0, then fetch: three cycles in all.
- R8: Any other opcode goes from decode straight back to fetch, with no reg_wr, mem_wr or pc_wr asserted after the fetch step.
- R9: alu_eq has no effect on any output outside the compare step; mem_rd and mem_wr are never both 1; iord=1 only in the data read and write steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W | Opcode field from the instruction register |
| alu_eq | input | 1 | ALU reports its two operands equal |
| pc_wr | output | 1 | PC write enable |
| pc_src | output | 2 | PC source: 00 ALU, 01 Target, 10 jump field |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU result |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register write enable |
| tgt_wr | output | 1 | Target register write enable |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 first register |
| alu_b_sel | output | 2 | ALU operand B: 00 second register, 01 four, 10 offset, 11 shifted offset |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function field |
| reg_wr | output | 1 | Register file write enable |
| mem2reg | output | 1 | Write-back data: 0 ALU, 1 memory |

## Verification
The assertions watch, on every cycle, the relations that hold whatever the opcode: fetch is always followed by decode, every final step of a path is followed by fetch, the compare step ties the PC write to the equality flag, memory is never read and written together, and an unknown opcode returns to fetch after decode. The exact control vector in each step, the cycle count of each path, the ordering of steps within a path and the effect of a reset in the middle of an instruction can only be shown by the bench walking each instruction class step by step and comparing every output against a vector built from the requirements.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_MADDR  = 4'd2,
      ST_MREAD  = 4'd3,
      ST_MWBK   = 4'd4,
      ST_MWRITE = 4'd5,
      ST_EXEC   = 4'd6,
      ST_AWBK   = 4'd7,
      ST_BCMP   = 4'd8,
      ST_JUMP   = 4'd9
   } ctl_state_e;

   localparam int NUM_STATES = 10;

   typedef enum logic [2:0] {
      CL_LOAD,
      CL_STORE,
      CL_RTYPE,
      CL_BRANCH,
      CL_JUMP,
      CL_NONE
   } op_class_e;

   localparam logic [1:0] PCS_ALU    = 2'b00;
   localparam logic [1:0] PCS_TGT    = 2'b01;
   localparam logic [1:0] PCS_JMP    = 2'b10;

   localparam logic [1:0] ALUB_REG   = 2'b00;
   localparam logic [1:0] ALUB_FOUR  = 2'b01;
   localparam logic [1:0] ALUB_IMM   = 2'b10;
   localparam logic [1:0] ALUB_IMMSH = 2'b11;

   localparam logic [1:0] ALUOP_ADD  = 2'b00;
   localparam logic [1:0] ALUOP_SUB  = 2'b01;
   localparam logic [1:0] ALUOP_FN   = 2'b10;

   typedef struct packed {
      logic       pc_wr;
      logic [1:0] pc_src;
      logic       iord;
      logic       mem_rd;
      logic       mem_wr;
      logic       ir_wr;
      logic       tgt_wr;
      logic       alu_a;
      logic [1:0] alu_b;
      logic [1:0] alu_op;
      logic       reg_wr;
      logic       mem2reg;
   } ctl_vec_t;

endpackage

// File: rtl/mcc_op_classify.sv
module mcc_op_classify #(
   parameter int                OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 'h23,
   parameter logic [OPC_W-1:0] OPC_STORE = 'h2B,
   parameter logic [OPC_W-1:0] OPC_RTYPE = 'h00,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 'h04,
   parameter logic [OPC_W-1:0] OPC_JUMP  = 'h02
) (
   input  logic [OPC_W-1:0]   opcode,
   output mcc_pkg::op_class_e cls
);
   import mcc_pkg::*;

   always_comb begin
      if (opcode == OPC_LOAD)        cls = CL_LOAD;
      else if (opcode == OPC_STORE)  cls = CL_STORE;
      else if (opcode == OPC_RTYPE)  cls = CL_RTYPE;
      else if (opcode == OPC_BEQ)    cls = CL_BRANCH;
      else if (opcode == OPC_JUMP)   cls = CL_JUMP;
      else                           cls = CL_NONE;
   end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state (
   input  mcc_pkg::ctl_state_e cur,
   input  mcc_pkg::op_class_e  cls,
   output mcc_pkg::ctl_state_e nxt
);
   import mcc_pkg::*;

   always_comb begin
      nxt = ST_FETCH;
      case (cur)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (cls)
               CL_LOAD,
               CL_STORE:  nxt = ST_MADDR;
               CL_RTYPE:  nxt = ST_EXEC;
               CL_BRANCH: nxt = ST_BCMP;
               CL_JUMP:   nxt = ST_JUMP;
               default:   nxt = ST_FETCH;
            endcase
         end
         ST_MADDR: begin
            if (cls == CL_LOAD)       nxt = ST_MREAD;
            else if (cls == CL_STORE) nxt = ST_MWRITE;
            else                      nxt = ST_FETCH;
         end
         ST_MREAD:  nxt = ST_MWBK;
         ST_EXEC:   nxt = ST_AWBK;
         default:   nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcc_state_store.sv
module mcc_state_store #(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  mcc_pkg::ctl_state_e nxt,
   output mcc_pkg::ctl_state_e cur
);
   import mcc_pkg::*;

   localparam int HOT_W = NUM_STATES;

   if (ONE_HOT) begin : g_onehot
      logic [HOT_W-1:0] hot_q;

      always_ff @(posedge clk) begin
         if (rst) hot_q <= HOT_W'(1) << ST_FETCH;
         else     hot_q <= HOT_W'(1) << nxt;
      end

      always_comb begin
         cur = ST_FETCH;
         for (int i = 0; i < HOT_W; i++) begin
            if (hot_q[i]) cur = ctl_state_e'(i[3:0]);
         end
      end
   end else begin : g_binary
      ctl_state_e st_q;

      always_ff @(posedge clk) begin
         if (rst) st_q <= ST_FETCH;
         else     st_q <= nxt;
      end

      assign cur = st_q;
   end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode (
   input  mcc_pkg::ctl_state_e cur,
   input  logic                alu_eq,
   output mcc_pkg::ctl_vec_t   v
);
   import mcc_pkg::*;

   always_comb begin
      v = '0;
      case (cur)
         ST_FETCH: begin
            v.mem_rd = 1'b1;
            v.iord   = 1'b0;
            v.ir_wr  = 1'b1;
            v.alu_a  = 1'b0;
            v.alu_b  = ALUB_FOUR;
            v.alu_op = ALUOP_ADD;
            v.pc_wr  = 1'b1;
            v.pc_src = PCS_ALU;
         end
         ST_DECODE: begin
            v.alu_a  = 1'b0;
            v.alu_b  = ALUB_IMMSH;
            v.alu_op = ALUOP_ADD;
            v.tgt_wr = 1'b1;
         end
         ST_MADDR: begin
            v.alu_a  = 1'b1;
            v.alu_b  = ALUB_IMM;
            v.alu_op = ALUOP_ADD;
         end
         ST_MREAD: begin
            v.mem_rd = 1'b1;
            v.iord   = 1'b1;
         end
         ST_MWBK: begin
            v.reg_wr  = 1'b1;
            v.mem2reg = 1'b1;
         end
         ST_MWRITE: begin
            v.mem_wr = 1'b1;
            v.iord   = 1'b1;
         end
         ST_EXEC: begin
            v.alu_a  = 1'b1;
            v.alu_b  = ALUB_REG;
            v.alu_op = ALUOP_FN;
         end
         ST_AWBK: begin
            v.reg_wr  = 1'b1;
            v.mem2reg = 1'b0;
         end
         ST_BCMP: begin
            v.alu_a  = 1'b1;
            v.alu_b  = ALUB_REG;
            v.alu_op = ALUOP_SUB;
            v.pc_src = PCS_TGT;
            v.pc_wr  = alu_eq;
         end
         ST_JUMP: begin
            v.pc_src = PCS_JMP;
            v.pc_wr  = 1'b1;
         end
         default: v = '0;
      endcase
   end

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl #(
   parameter int                OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 'h23,
   parameter logic [OPC_W-1:0] OPC_STORE = 'h2B,
   parameter logic [OPC_W-1:0] OPC_RTYPE = 'h00,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 'h04,
   parameter logic [OPC_W-1:0] OPC_JUMP  = 'h02,
   parameter bit                ONE_HOT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   input  logic             alu_eq,
   output logic             pc_wr,
   output logic [1:0]       pc_src,
   output logic             iord,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             ir_wr,
   output logic             tgt_wr,
   output logic             alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic [1:0]       alu_op,
   output logic             reg_wr,
   output logic             mem2reg
);
   import mcc_pkg::*;

   localparam bit OPC_DISTINCT =
      (OPC_LOAD  != OPC_STORE) && (OPC_LOAD  != OPC_RTYPE) &&
      (OPC_LOAD  != OPC_BEQ)   && (OPC_LOAD  != OPC_JUMP)  &&
      (OPC_STORE != OPC_RTYPE) && (OPC_STORE != OPC_BEQ)   &&
      (OPC_STORE != OPC_JUMP)  && (OPC_RTYPE != OPC_BEQ)   &&
      (OPC_RTYPE != OPC_JUMP)  && (OPC_BEQ   != OPC_JUMP);

   if (OPC_W < 3) begin : g_bad_width
      $error("mcc_ctrl: OPC_W must be at least 3 to hold five distinct opcodes");
   end
   if (!OPC_DISTINCT) begin : g_bad_codes
      $error("mcc_ctrl: the five opcode parameters must all differ");
   end

   op_class_e  cls;
   ctl_state_e cur_st;
   ctl_state_e nxt_st;
   ctl_vec_t   vec;

   mcc_op_classify #(
      .OPC_W    (OPC_W),
      .OPC_LOAD (OPC_LOAD),
      .OPC_STORE(OPC_STORE),
      .OPC_RTYPE(OPC_RTYPE),
      .OPC_BEQ  (OPC_BEQ),
      .OPC_JUMP (OPC_JUMP)
   ) u_cls (
      .opcode(opcode),
      .cls   (cls)
   );

   mcc_next_state u_nxt (
      .cur(cur_st),
      .cls(cls),
      .nxt(nxt_st)
   );

   mcc_state_store #(
      .ONE_HOT(ONE_HOT)
   ) u_st (
      .clk(clk),
      .rst(rst),
      .nxt(nxt_st),
      .cur(cur_st)
   );

   mcc_out_decode u_out (
      .cur   (cur_st),
      .alu_eq(alu_eq),
      .v     (vec)
   );

   assign pc_wr     = vec.pc_wr;
   assign pc_src    = vec.pc_src;
   assign iord      = vec.iord;
   assign mem_rd    = vec.mem_rd;
   assign mem_wr    = vec.mem_wr;
   assign ir_wr     = vec.ir_wr;
   assign tgt_wr    = vec.tgt_wr;
   assign alu_a_sel = vec.alu_a;
   assign alu_b_sel = vec.alu_b;
   assign alu_op    = vec.alu_op;
   assign reg_wr    = vec.reg_wr;
   assign mem2reg   = vec.mem2reg;

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk #(
   parameter int                OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 'h23,
   parameter logic [OPC_W-1:0] OPC_STORE = 'h2B,
   parameter logic [OPC_W-1:0] OPC_RTYPE = 'h00,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 'h04,
   parameter logic [OPC_W-1:0] OPC_JUMP  = 'h02
) (
   input logic             clk,
   input logic             rst,
   input logic [OPC_W-1:0] opcode,
   input logic             alu_eq,
   input logic             pc_wr,
   input logic [1:0]       pc_src,
   input logic             iord,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             ir_wr,
   input logic             tgt_wr,
   input logic [1:0]       alu_op,
   input logic             reg_wr,
   input logic             mem2reg
);

   logic op_known;
   assign op_known = (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                     (opcode == OPC_RTYPE) || (opcode == OPC_BEQ) ||
                     (opcode == OPC_JUMP);

   // R1
   reset_to_fetch_chk: assert property (@(posedge clk)
      rst |=> (ir_wr && pc_wr && mem_rd && !iord));

   // R2
   fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
      ir_wr |=> (tgt_wr && !ir_wr && !pc_wr));

   // R3
   load_wb_returns_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && mem2reg) |=> ir_wr);

   // R4
   store_returns_chk: assert property (@(posedge clk) disable iff (rst)
      mem_wr |=> ir_wr);

   // R5
   exec_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
      (alu_op == 2'b10) |=> (reg_wr && !mem2reg));

   // R6
   branch_follows_eq_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_src == 2'b01) |-> (pc_wr == alu_eq));

   // R7
   jump_no_target_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_src == 2'b10) |-> (pc_wr && !tgt_wr));

   // R8
   unknown_back_chk: assert property (@(posedge clk) disable iff (rst)
      (tgt_wr && !op_known) |=> (ir_wr && !reg_wr && !mem_wr));

   // R9
   no_rd_wr_clash_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R9
   iord_data_only_chk: assert property (@(posedge clk) disable iff (rst)
      iord |-> ((mem_rd ^ mem_wr) && !ir_wr));

endmodule

bind mcc_ctrl mcc_ctrl_chk #(
   .OPC_W    (OPC_W),
   .OPC_LOAD (OPC_LOAD),
   .OPC_STORE(OPC_STORE),
   .OPC_RTYPE(OPC_RTYPE),
   .OPC_BEQ  (OPC_BEQ),
   .OPC_JUMP (OPC_JUMP)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .opcode (opcode),
   .alu_eq (alu_eq),
   .pc_wr  (pc_wr),
   .pc_src (pc_src),
   .iord   (iord),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .ir_wr  (ir_wr),
   .tgt_wr (tgt_wr),
   .alu_op (alu_op),
   .reg_wr (reg_wr),
   .mem2reg(mem2reg)
);

// File: tb/tb_mcc_ctrl.sv
module tb_mcc_ctrl;

   localparam logic [5:0] OP_LW  = 6'h23;
   localparam logic [5:0] OP_SW  = 6'h2B;
   localparam logic [5:0] OP_R   = 6'h00;
   localparam logic [5:0] OP_BEQ = 6'h04;
   localparam logic [5:0] OP_J   = 6'h02;

   // bench step codes: 0 fetch, 1 decode, 2 addr, 3 read, 4 load wb,
   // 5 write, 6 exec, 7 alu wb, 8 compare, 9 jump
   // entry: {opcode[5:0], eq, len[2:0], five step nibbles, first in low nibble}
   localparam int NVEC = 9;
   localparam logic [29:0] TBL [NVEC] = '{
      {OP_LW,  1'b0, 3'd5, 20'h43210},
      {OP_SW,  1'b0, 3'd4, 20'h05210},
      {OP_R,   1'b0, 3'd4, 20'h07610},
      {OP_BEQ, 1'b1, 3'd3, 20'h00810},
      {OP_BEQ, 1'b0, 3'd3, 20'h00810},
      {OP_J,   1'b0, 3'd3, 20'h00910},
      {6'h3F,  1'b1, 3'd2, 20'h00010},
      {OP_LW,  1'b1, 3'd5, 20'h43210},
      {6'h05,  1'b0, 3'd2, 20'h00010}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'h00;
   logic       alu_eq = 1'b0;
   logic       pc_wr, iord, mem_rd, mem_wr, ir_wr, tgt_wr, alu_a_sel, reg_wr, mem2reg;
   logic [1:0] pc_src, alu_b_sel, alu_op;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   mcc_ctrl dut (
      .clk(clk), .rst(rst), .opcode(opcode), .alu_eq(alu_eq),
      .pc_wr(pc_wr), .pc_src(pc_src), .iord(iord), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .ir_wr(ir_wr), .tgt_wr(tgt_wr), .alu_a_sel(alu_a_sel),
      .alu_b_sel(alu_b_sel), .alu_op(alu_op), .reg_wr(reg_wr), .mem2reg(mem2reg)
   );

   // {pc_wr, pc_src, iord, mem_rd, mem_wr, ir_wr, tgt_wr, alu_a, alu_b, alu_op, reg_wr, mem2reg}
   function automatic logic [14:0] exp_vec(int s, logic eq);
      case (s)
         0: return 15'b1_00_0_1_0_1_0_0_01_00_0_0;
         1: return 15'b0_00_0_0_0_0_1_0_11_00_0_0;
         2: return 15'b0_00_0_0_0_0_0_1_10_00_0_0;
         3: return 15'b0_00_1_1_0_0_0_0_00_00_0_0;
         4: return 15'b0_00_0_0_0_0_0_0_00_00_1_1;
         5: return 15'b0_00_1_0_1_0_0_0_00_00_0_0;
         6: return 15'b0_00_0_0_0_0_0_1_00_10_0_0;
         7: return 15'b0_00_0_0_0_0_0_0_00_00_1_0;
         8: return {eq, 14'b01_0_0_0_0_0_1_00_01_0_0};
         9: return 15'b1_10_0_0_0_0_0_0_00_00_0_0;
         default: return 15'h0;
      endcase
   endfunction

   function automatic string tag_of(int s, logic [5:0] op, logic eq);
      if (op != OP_LW && op != OP_SW && op != OP_R && op != OP_BEQ && op != OP_J)
         return (s == 0) ? "R1" : "R8";
      if (s == 0) return "R1";
      if (s == 1) return "R2";
      if (op == OP_LW && eq) return "R9";
      case (s)
         2, 3, 4: return (op == OP_LW) ? "R3" : "R4";
         5:       return "R4";
         6, 7:    return "R5";
         8:       return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input logic [14:0] exp, input string tag);
      logic [14:0] got;
      got = {pc_wr, pc_src, iord, mem_rd, mem_wr, ir_wr, tgt_wr,
             alu_a_sel, alu_b_sel, alu_op, reg_wr, mem2reg};
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // called just after a falling edge; returns at the next falling edge
   task automatic step(input logic [5:0] op, input logic eq, input int s, input string tag);
      opcode = op;
      alu_eq = eq;
      #1;
      chk(exp_vec(s, eq), tag);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset held keeps the fetch vector, whatever the opcode
      step(OP_LW, 1'b0, 0, "R1");
      step(OP_J,  1'b1, 0, "R1");
      rst = 1'b0;

      // table walk: each instruction class step by step
      for (int e = 0; e < NVEC; e++) begin
         logic [5:0]  op;
         logic        eq;
         logic [2:0]  len;
         logic [19:0] seq;
         {op, eq, len, seq} = TBL[e];
         for (int k = 0; k < int'(len); k++) begin
            int s;
            s = int'(seq[4*k +: 4]);
            step(op, eq, s, tag_of(s, op, eq));
         end
      end
      // R1: after the last entry the sequencer is back in fetch
      step(OP_R, 1'b0, 0, "R1");

      // R1: reset in the middle of a load returns to fetch
      step(OP_LW, 1'b0, 1, "R2");
      step(OP_LW, 1'b0, 2, "R3");
      rst = 1'b1;
      step(OP_LW, 1'b0, 3, "R3");
      rst = 1'b0;
      step(OP_LW, 1'b0, 0, "R1");
      step(OP_LW, 1'b0, 1, "R2");
      step(OP_LW, 1'b0, 2, "R3");
      step(OP_LW, 1'b0, 3, "R3");
      step(OP_LW, 1'b0, 4, "R3");

      // R6: pc_wr tracks alu_eq inside the compare cycle
      step(OP_BEQ, 1'b0, 0, "R1");
      step(OP_BEQ, 1'b0, 1, "R2");
      opcode = OP_BEQ;
      alu_eq = 1'b0;
      #1 chk(exp_vec(8, 1'b0), "R6");
      alu_eq = 1'b1;
      #0.5 chk(exp_vec(8, 1'b1), "R6");
      @(negedge clk);

      // R9: alu_eq toggling in the execute step changes nothing
      step(OP_R, 1'b1, 0, "R1");
      step(OP_R, 1'b0, 1, "R2");
      opcode = OP_R;
      alu_eq = 1'b0;
      #1 chk(exp_vec(6, 1'b0), "R9");
      alu_eq = 1'b1;
      #0.5 chk(exp_vec(6, 1'b0), "R9");
      @(negedge clk);
      step(OP_R, 1'b1, 7, "R5");
      step(OP_R, 1'b0, 0, "R1");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule